// File: doc/BRIEF.md
# Circuit-Switched Link Reservation Controller

This block holds the reservation state of one router in a two-dimensional mesh that uses circuit switching. The router has five ports. A setup flit reserves the output link chosen by X-then-Y dimension-ordered routing, and the setup moves on only through that reserved link. The acknowledgement flit sent back by the destination is steered to the input that owns the link. Data flits then follow the chain of reserved links without waiting in any per-hop queue. A tail flit follows the same path and frees each reservation behind it.

A setup whose output is already reserved stalls in a single held slot on its input until a tail frees the link. When several setups want the same free output in the same cycle, a fixed priority picks one. A data, tail or acknowledgement flit that finds no matching reservation is dropped, and a sticky error flag is set. All outputs are registered, so a flit that arrives in one cycle leaves in the next.

Top module: `cs_link_ctrl`

## Requirements
- R1: Port indices are fixed: 0 local, 1 north (towards larger Y), 2 east (towards larger X), 3 south, 4 west. With the default parameters a flit is 16 bits: bits [15:14] hold the type (00 setup, 01 acknowledge, 10 data, 11 tail), bits [13:11] the destination X, bits [10:8] the destination Y and bits [7:0] the payload. A setup is routed east if its destination X is above MY_X and west if it is below. When X matches, it goes north if its destination Y is above MY_Y and south if it is below. When both match, it goes local.
- R2: A setup that wins a free output appears unchanged on that output in the cycle after it arrives, and that output is reserved for its input from then on.
- R3: A setup whose output is reserved produces no output and is held. It is granted in the second cycle after the tail that frees the link arrives.
- R4: A data flit on an input that owns a reservation appears unchanged, one cycle later, on the reserved output.
- R5: An acknowledgement arriving on port p leaves, one cycle later, on the port whose input owns output p.
- R6: A tail flit is forwarded like data, and it releases the reservation of its output.
- R7: When several setups request the same free output in one cycle, the priority is local, north, east, south, west. The losers stay held and are served in that order as the link is freed.
- R8: A data, tail or acknowledgement flit with no matching reservation produces no output. It sets the error flag, which stays set until reset.
- R9: After reset no output is valid, no link is reserved and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 5 | Per-port input flit valid |
| in_flit | input | 5 x FLIT_W | Per-port input flit |
| out_vld | output | 5 | Per-port output flit valid |
| out_flit | output | 5 x FLIT_W | Per-port output flit |
| err_flag | output | 1 | Sticky error for unmatched flits |

## Verification
The bench builds the block with its defaults: 3-bit coordinates and the router placed at (2,2) in an 8 by 8 mesh. This placement makes every one of the five routing outcomes reachable from random destinations, on both sides of the router in each dimension. Directed sequences build a full circuit: setup, acknowledgement, data and tail. While that circuit is live, they stall a competing setup and then release it. Three setups collide on the local output to show the priority order. A stray data flit shows the sticky error.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int NPORT = 5;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] P_LOCAL = 3'd0;
    localparam logic [IDX_W-1:0] P_NORTH = 3'd1;
    localparam logic [IDX_W-1:0] P_EAST  = 3'd2;
    localparam logic [IDX_W-1:0] P_SOUTH = 3'd3;
    localparam logic [IDX_W-1:0] P_WEST  = 3'd4;

    typedef enum logic [1:0] {
        FT_SETUP = 2'b00,
        FT_ACK   = 2'b01,
        FT_DATA  = 2'b10,
        FT_TAIL  = 2'b11
    } flit_kind_e;
endpackage

// File: rtl/cs_xy_route.sv
module cs_xy_route #(
    parameter int X_W  = 3,
    parameter int Y_W  = 3,
    parameter int MY_X = 2,
    parameter int MY_Y = 2
) (
    input  logic [X_W-1:0]           dst_x,
    input  logic [Y_W-1:0]           dst_y,
    output logic [cs_pkg::IDX_W-1:0] port
);
    localparam logic [X_W-1:0] HERE_X = X_W'(MY_X);
    localparam logic [Y_W-1:0] HERE_Y = Y_W'(MY_Y);

    always_comb begin
        if (dst_x > HERE_X)      port = cs_pkg::P_EAST;
        else if (dst_x < HERE_X) port = cs_pkg::P_WEST;
        else if (dst_y > HERE_Y) port = cs_pkg::P_NORTH;
        else if (dst_y < HERE_Y) port = cs_pkg::P_SOUTH;
        else                     port = cs_pkg::P_LOCAL;
    end
endmodule

// File: rtl/cs_prio_arb.sv
module cs_prio_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    always_comb begin
        a_r7_single_grant: assert ($onehot0(gnt));
    end
endmodule

// File: rtl/cs_link_ctrl.sv
module cs_link_ctrl
    import cs_pkg::*;
#(
    parameter int X_W   = 3,
    parameter int Y_W   = 3,
    parameter int PAY_W = 8,
    parameter int MY_X  = 2,
    parameter int MY_Y  = 2,
    localparam int FLIT_W = 2 + X_W + Y_W + PAY_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              in_vld,
    input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
    output logic [NPORT-1:0]              out_vld,
    output logic [NPORT-1:0][FLIT_W-1:0]  out_flit,
    output logic                          err_flag
);
    localparam int TY_LSB = FLIT_W - 2;
    localparam int DX_LSB = PAY_W + Y_W;
    localparam int DY_LSB = PAY_W;

    typedef struct packed {
        logic [NPORT-1:0]              owner_vld;
        logic [NPORT-1:0][IDX_W-1:0]   owner_idx;
        logic [NPORT-1:0]              held_vld;
        logic [NPORT-1:0][FLIT_W-1:0]  held_flit;
        logic [NPORT-1:0]              out_vld;
        logic [NPORT-1:0][FLIT_W-1:0]  out_flit;
        logic                          err;
    } state_t;

    state_t st_d, st_q;

    logic [NPORT-1:0]              req_vld;
    logic [NPORT-1:0][FLIT_W-1:0]  req_flit;
    logic [NPORT-1:0][IDX_W-1:0]   req_port;
    logic [NPORT-1:0][NPORT-1:0]   req_m;
    logic [NPORT-1:0][NPORT-1:0]   gnt_m;
    logic [NPORT-1:0]              ack_hit;
    logic [NPORT-1:0][FLIT_W-1:0]  ack_flit;
    logic                          ack_err;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign req_vld[i]  = st_q.held_vld[i] ||
                             (in_vld[i] && in_flit[i][TY_LSB +: 2] == FT_SETUP);
        assign req_flit[i] = st_q.held_vld[i] ? st_q.held_flit[i] : in_flit[i];

        cs_xy_route #(
            .X_W (X_W),
            .Y_W (Y_W),
            .MY_X(MY_X),
            .MY_Y(MY_Y)
        ) u_route (
            .dst_x(req_flit[i][DX_LSB +: X_W]),
            .dst_y(req_flit[i][DY_LSB +: Y_W]),
            .port (req_port[i])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        for (genvar i = 0; i < NPORT; i++) begin : g_req
            assign req_m[o][i] = req_vld[i] && req_port[i] == IDX_W'(o) &&
                                 !st_q.owner_vld[o] && !ack_hit[o];
        end

        cs_prio_arb #(.N(NPORT)) u_arb (
            .req(req_m[o]),
            .gnt(gnt_m[o])
        );
    end

    // Acknowledgements travel the reverse of the owner mapping.
    always_comb begin
        ack_hit  = '0;
        ack_flit = '0;
        ack_err  = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (in_vld[p] && in_flit[p][TY_LSB +: 2] == FT_ACK) begin
                if (st_q.owner_vld[p]) begin
                    for (int t = 0; t < NPORT; t++) begin
                        if (st_q.owner_idx[p] == IDX_W'(t)) begin
                            ack_hit[t]  = 1'b1;
                            ack_flit[t] = in_flit[p];
                        end
                    end
                end else begin
                    ack_err = 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic found;
        logic granted;
        st_d          = st_q;
        st_d.out_vld  = '0;
        st_d.out_flit = '0;
        if (ack_err) st_d.err = 1'b1;

        // Data and tail follow the forward reservation.
        for (int i = 0; i < NPORT; i++) begin
            found = 1'b0;
            if (in_vld[i] && in_flit[i][TY_LSB + 1]) begin
                for (int o = 0; o < NPORT; o++) begin
                    if (st_q.owner_vld[o] && st_q.owner_idx[o] == IDX_W'(i)) begin
                        found            = 1'b1;
                        st_d.out_vld[o]  = 1'b1;
                        st_d.out_flit[o] = in_flit[i];
                        if (in_flit[i][TY_LSB +: 2] == FT_TAIL)
                            st_d.owner_vld[o] = 1'b0;
                    end
                end
                if (!found) st_d.err = 1'b1;
            end
        end

        // Forwarded traffic wins over a returning acknowledgement.
        for (int o = 0; o < NPORT; o++) begin
            if (ack_hit[o] && !st_d.out_vld[o]) begin
                st_d.out_vld[o]  = 1'b1;
                st_d.out_flit[o] = ack_flit[o];
            end
        end

        // Setup grants reserve a free output.
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_m[o][i]) begin
                    st_d.owner_vld[o] = 1'b1;
                    st_d.owner_idx[o] = IDX_W'(i);
                    st_d.out_vld[o]   = 1'b1;
                    st_d.out_flit[o]  = req_flit[i];
                end
            end
        end

        for (int i = 0; i < NPORT; i++) begin
            granted = 1'b0;
            for (int o = 0; o < NPORT; o++) granted = granted | gnt_m[o][i];
            st_d.held_vld[i]  = req_vld[i] && !granted;
            st_d.held_flit[i] = req_flit[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.out_vld;
    assign out_flit = st_q.out_flit;
    assign err_flag = st_q.err;

    for (genvar o = 0; o < NPORT; o++) begin : g_chk
        a_r2_setup_reserves: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[o] && out_flit[o][TY_LSB +: 2] == FT_SETUP) |-> st_q.owner_vld[o]);
        a_r3_setup_was_free: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[o] && out_flit[o][TY_LSB +: 2] == FT_SETUP) |-> !$past(st_q.owner_vld[o]));
        a_r4_data_on_owned: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[o] && out_flit[o][TY_LSB +: 2] == FT_DATA) |-> $past(st_q.owner_vld[o]));
        a_r6_tail_frees: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[o] && out_flit[o][TY_LSB +: 2] == FT_TAIL) |-> !st_q.owner_vld[o]);
    end

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: tb/cs_link_ctrl_tb.sv
module cs_link_ctrl_tb;
    localparam int NP = 5;
    localparam int FW = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      in_vld = '0;
    logic [NP-1:0][FW-1:0] in_flit = '0;
    logic [NP-1:0]      out_vld;
    logic [NP-1:0][FW-1:0] out_flit;
    logic               err_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cs_link_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
        .out_vld(out_vld), .out_flit(out_flit), .err_flag(err_flag)
    );

    function automatic logic [FW-1:0] mk(input logic [1:0] ty, input int x, input int y, input int pay);
        return {ty, 3'(x), 3'(y), 8'(pay)};
    endfunction

    function automatic int exp_port(input int x, input int y);
        if (x > 2) return 2;
        if (x < 2) return 4;
        if (y > 2) return 1;
        if (y < 2) return 3;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle, then sample outputs at the following negedge
    task automatic send(input logic [NP-1:0] v, input logic [NP-1:0][FW-1:0] f);
        in_vld  = v;
        in_flit = f;
        @(negedge clk);
        in_vld  = '0;
        in_flit = '0;
    endtask

    task automatic send1(input int p, input logic [FW-1:0] f);
        logic [NP-1:0][FW-1:0] fl;
        fl = '0;
        fl[p] = f;
        send(NP'(1) << p, fl);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0][FW-1:0] fl;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 out_vld", 32'(out_vld), 0);
        chk("R9 err", 32'(err_flag), 0);

        // R1 routing over random destinations, each closed with a tail (R6)
        for (int k = 0; k < 30; k++) begin
            int s, x, y, e;
            logic [FW-1:0] f;
            s = int'($urandom % 5);
            x = int'($urandom % 8);
            y = int'($urandom % 8);
            e = exp_port(x, y);
            f = mk(2'b00, x, y, k);
            send1(s, f);
            chk("R1 route vld", 32'(out_vld), 32'(1 << e));
            chk("R2 setup flit", 32'(out_flit[e]), 32'(f));
            f = mk(2'b11, x, y, k + 100);
            send1(s, f);
            chk("R6 tail vld", 32'(out_vld), 32'(1 << e));
            chk("R6 tail flit", 32'(out_flit[e]), 32'(f));
        end

        // Full circuit from local towards east
        send1(0, mk(2'b00, 3, 2, 8'h11));
        chk("R2 setup east", 32'(out_vld), 32'b00100);
        send1(2, mk(2'b01, 0, 0, 8'h22));
        chk("R5 ack to local vld", 32'(out_vld), 32'b00001);
        chk("R5 ack flit", 32'(out_flit[0]), 32'(mk(2'b01, 0, 0, 8'h22)));
        send1(0, mk(2'b10, 3, 2, 8'h5a));
        chk("R4 data vld", 32'(out_vld), 32'b00100);
        chk("R4 data flit", 32'(out_flit[2]), 32'(mk(2'b10, 3, 2, 8'h5a)));
        // competing setup from west input wants east
        send1(4, mk(2'b00, 5, 0, 8'h33));
        chk("R3 stalled", 32'(out_vld), 0);
        idle();
        chk("R3 still stalled", 32'(out_vld), 0);
        send1(0, mk(2'b11, 3, 2, 8'h44));
        chk("R6 tail east", 32'(out_vld), 32'b00100);
        idle();
        chk("R3 released vld", 32'(out_vld), 32'b00100);
        chk("R3 released flit", 32'(out_flit[2]), 32'(mk(2'b00, 5, 0, 8'h33)));
        send1(4, mk(2'b11, 5, 0, 8'h34));
        chk("R6 west tail", 32'(out_vld), 32'b00100);

        // R7 three setups collide on local output
        fl = '0;
        fl[1] = mk(2'b00, 2, 2, 8'h01);
        fl[3] = mk(2'b00, 2, 2, 8'h03);
        fl[4] = mk(2'b00, 2, 2, 8'h04);
        send(5'b11010, fl);
        chk("R7 north wins", 32'(out_flit[0]), 32'(fl[1]));
        chk("R7 one output", 32'(out_vld), 32'b00001);
        send1(1, mk(2'b11, 2, 2, 8'h91));
        idle();
        chk("R7 south next", 32'(out_flit[0]), 32'(fl[3]));
        send1(3, mk(2'b11, 2, 2, 8'h93));
        idle();
        chk("R7 west last", 32'(out_flit[0]), 32'(fl[4]));
        send1(4, mk(2'b11, 2, 2, 8'h94));
        chk("R6 final tail", 32'(out_vld), 32'b00001);
        chk("R8 err clear so far", 32'(err_flag), 0);

        // R8 unmatched data and ack
        send1(3, mk(2'b10, 0, 0, 8'h77));
        chk("R8 dropped", 32'(out_vld), 0);
        chk("R8 err set", 32'(err_flag), 1);
        send1(2, mk(2'b01, 0, 0, 8'h78));
        chk("R8 ack dropped", 32'(out_vld), 0);
        idle();
        chk("R8 err sticky", 32'(err_flag), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule